// File: doc/BRIEF.md
# Hsync-Referenced Clamp Pulse Generator

This block makes the black-level clamp strobe for a three-channel video digitizer. In internal mode it watches the horizontal sync input. On each leading edge of sync it waits a programmed number of pixel clocks and then raises the clamp strobe for a programmed number of pixel clocks. In external mode it passes a dedicated clamp pin to the output, after correcting the pin's polarity.

Along with the strobe, the block gives each colour channel a target code. The code is 0 when that channel clamps to ground and half of full scale when it clamps to midscale. The analog clamp switches use the strobe to clamp all three channels together, and each channel aims for its own code.

Top module: `clamp_pulse_gen`

## Requirements
- R1: While reset is held, and after it is released with no sync edge yet seen, `clamp_on` is 0 in internal mode.
- R2: Sync is normalized before edge detection. `hsync_pol`=1 means sync is active high and 0 means active low. A leading edge is an inactive-to-active change seen at one clock edge compared with the previous clock edge. A sync level that is already active when reset is released is not a leading edge.
- R3: Cycle 0 is the clock cycle that follows the clock edge that detects a leading edge. In internal mode, `clamp_on` is 1 from cycle `placement` through cycle `placement+duration-1` and 0 at all other times. Placement and duration are sampled at the detecting edge, so changing them later does not change a pulse already in progress.
- R4: A duration of 0 produces no internal clamp pulse for that line, whatever the placement.
- R5: A leading edge that arrives while a pulse is pending or active restarts the count from that edge.
- R6: In external mode, `clamp_on` follows `ext_clamp` directly, with no clock delay. It equals the pin when `ext_pol`=1 and the inverted pin when `ext_pol`=0.
- R7: `clk_src`=0 selects the internal timing and `clk_src`=1 selects the external pin. The selection takes effect at once, and the internal counter keeps running underneath in both modes.
- R8: `lvl_sel` bit 0 belongs to red, bit 1 to green and bit 2 to blue. Each code output is 128 when its bit is 1 (midscale) and 0 when its bit is 0 (ground). The code outputs do not depend on clamp timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync_in | input | 1 | Horizontal sync |
| hsync_pol | input | 1 | 1: sync active high, 0: active low |
| ext_clamp | input | 1 | External clamp pin |
| ext_pol | input | 1 | 1: pin active high, 0: active low |
| clk_src | input | 1 | Clamp timing source, 0 internal, 1 external |
| placement | input | 8 | Delay from sync leading edge to clamp start, in clocks |
| duration | input | 8 | Clamp length in clocks |
| lvl_sel | input | 3 | Midscale selects: bit 0 red, bit 1 green, bit 2 blue |
| clamp_on | output | 1 | Clamp active strobe, shared by all channels |
| code_r | output | 8 | Red clamp target code |
| code_g | output | 8 | Green clamp target code |
| code_b | output | 8 | Blue clamp target code |

## Verification
The assertions run on every cycle. They cover the target codes, which must be either 0 or the midscale value and must follow their select bits, and the external path in both polarities. They also check the cycle right after a detected sync edge: the strobe must be low there for a zero duration or a nonzero placement, and high there for a zero placement with a nonzero duration. The full shape of each pulse needs the bench's reference model, which compares the strobe on every clock. That covers where each pulse ends, the restart when sync arrives early, settings changed in the middle of a line, the ignored edge at reset release, and active-low sync.

// File: rtl/clamp_pulse_gen.sv
module clamp_pulse_gen #(
  parameter int PW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hsync_in,
  input  logic          hsync_pol,
  input  logic          ext_clamp,
  input  logic          ext_pol,
  input  logic          clk_src,
  input  logic [PW-1:0] placement,
  input  logic [PW-1:0] duration,
  input  logic [2:0]    lvl_sel,
  output logic          clamp_on,
  output logic [DW-1:0] code_r,
  output logic [DW-1:0] code_g,
  output logic [DW-1:0] code_b
);
  localparam int CW = PW + 1;
  localparam logic [DW-1:0] MID = DW'(1) << (DW - 1);

  logic          hs_act, hs_q, lead, run;
  logic [CW-1:0] cnt, stop_at, cnt_nx;
  logic [PW-1:0] pl_q, du_q;
  logic          int_on, ext_on;

  assign hs_act  = hsync_pol ? hsync_in : ~hsync_in;
  assign lead    = hs_act & ~hs_q;
  assign stop_at = {1'b0, pl_q} + {1'b0, du_q};
  assign cnt_nx  = cnt + CW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_q <= 1'b1;
      run  <= 1'b0;
      cnt  <= '0;
      pl_q <= '0;
      du_q <= '0;
    end else begin
      hs_q <= hs_act;
      if (lead) begin
        run  <= 1'b1;
        cnt  <= '0;
        pl_q <= placement;
        du_q <= duration;
      end else if (run) begin
        if (cnt_nx >= stop_at) run <= 1'b0;
        else cnt <= cnt_nx;
      end
    end
  end

  assign int_on   = run && (cnt >= {1'b0, pl_q}) && (cnt < stop_at);
  assign ext_on   = ext_pol ? ext_clamp : ~ext_clamp;
  assign clamp_on = clk_src ? ext_on : int_on;

  assign code_r = lvl_sel[0] ? MID : '0;
  assign code_g = lvl_sel[1] ? MID : '0;
  assign code_b = lvl_sel[2] ? MID : '0;
endmodule

// File: rtl/clamp_pulse_gen_chk.sv
module clamp_pulse_gen_chk #(
  parameter int PW = 8,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hsync_in,
  input logic          hsync_pol,
  input logic          ext_clamp,
  input logic          ext_pol,
  input logic          clk_src,
  input logic [PW-1:0] placement,
  input logic [PW-1:0] duration,
  input logic [2:0]    lvl_sel,
  input logic          clamp_on,
  input logic [DW-1:0] code_r,
  input logic [DW-1:0] code_g,
  input logic [DW-1:0] code_b
);
  logic seen_prev, edge_seen;
  assign edge_seen = (hsync_in == hsync_pol) && !seen_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) seen_prev <= 1'b1;
    else        seen_prev <= (hsync_in == hsync_pol);
  end

  assert_code_shape_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (code_r[DW-2:0] == '0) && (code_g[DW-2:0] == '0) && (code_b[DW-2:0] == '0));

  assert_code_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (code_r[DW-1] == lvl_sel[0]) && (code_g[DW-1] == lvl_sel[1]) && (code_b[DW-1] == lvl_sel[2]));

  assert_ext_path_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clk_src |-> (clamp_on == (ext_pol ? ext_clamp : !ext_clamp)));

  assert_zero_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_seen && duration == '0) |=> (clk_src || !clamp_on));

  assert_late_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_seen && placement != '0) |=> (clk_src || !clamp_on));

  assert_early_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_seen && placement == '0 && duration != '0) |=> (clk_src || clamp_on));
endmodule

bind clamp_pulse_gen clamp_pulse_gen_chk #(.PW(PW), .DW(DW)) u_chk (.*);

// File: tb/clamp_pulse_gen_bench.sv
module clamp_pulse_gen_bench;
  logic clk = 0, rst_n = 0;
  logic hsync_in = 0, hsync_pol = 1, ext_clamp = 0, ext_pol = 1, clk_src = 0;
  logic [7:0] placement = 0, duration = 0;
  logic [2:0] lvl_sel = 0;
  logic clamp_on;
  logic [7:0] code_r, code_g, code_b;

  int total = 0, bad = 0;
  string cur_req = "R1";
  bit hung = 0;

  always #4 clk = ~clk;

  clamp_pulse_gen u_clamp_pulse_gen (.*);

  bit prev_act = 1;
  int since = -1, m_pl = 0, m_du = 0;

  function automatic bit exp_clamp();
    bit act_int;
    act_int = (since >= 0) && (since >= m_pl) && (since < m_pl + m_du);
    if (clk_src) return ext_pol ? ext_clamp : !ext_clamp;
    return act_int;
  endfunction

  always @(posedge clk) begin
    bit act;
    act = hsync_pol ? hsync_in : !hsync_in;
    if (!rst_n) begin
      prev_act = 1;
      since = -1;
    end else begin
      if (act && !prev_act) begin
        since = 0;
        m_pl = placement;
        m_du = duration;
      end else if (since >= 0 && since < 1000) begin
        since++;
      end
      prev_act = act;
    end
    #2;
    begin
      bit e;
      logic [7:0] er, eg, eb;
      e  = rst_n ? exp_clamp() : 1'b0;
      er = lvl_sel[0] ? 8'd128 : 8'd0;
      eg = lvl_sel[1] ? 8'd128 : 8'd0;
      eb = lvl_sel[2] ? 8'd128 : 8'd0;
      total++;
      if (clamp_on !== e) begin
        bad++;
        $display("FAIL %s clamp_on actual=%b expected=%b t=%0t", cur_req, clamp_on, e, $time);
      end
      total++;
      if (code_r !== er || code_g !== eg || code_b !== eb) begin
        bad++;
        $display("FAIL R8 codes actual=%0d/%0d/%0d expected=%0d/%0d/%0d", code_r, code_g, code_b, er, eg, eb);
      end
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_hs(bit active);
    hsync_in = hsync_pol ? active : !active;
  endtask

  task automatic line(int hi, int lo);
    set_hs(1); wait_cyc(hi);
    set_hs(0); wait_cyc(lo);
  endtask

  initial begin
    #(200000 * 8);
    hung = 1;
  end

  initial begin
    // R1 / R2: sync held active through reset release must not count as an edge
    hsync_pol = 1; hsync_in = 1; placement = 0; duration = 4;
    wait_cyc(4);
    cur_req = "R1";
    rst_n = 1;
    wait_cyc(8);
    cur_req = "R2";
    set_hs(0); wait_cyc(4);

    // R3: nonzero placement and duration
    cur_req = "R3";
    placement = 3; duration = 4;
    repeat (3) line(2, 14);
    placement = 0; duration = 5;
    repeat (2) line(3, 12);
    placement = 255; duration = 2;
    line(2, 262);

    // R3: settings changed mid-line are ignored until the next edge
    placement = 2; duration = 6;
    set_hs(1); wait_cyc(1);
    placement = 9; duration = 1;
    wait_cyc(1); set_hs(0); wait_cyc(14);

    // R4: zero duration
    cur_req = "R4";
    placement = 2; duration = 0;
    repeat (2) line(2, 10);
    placement = 0;
    line(2, 10);

    // R5: early sync restarts the count
    cur_req = "R5";
    placement = 1; duration = 20;
    repeat (4) line(2, 6);
    wait_cyc(24);

    // R2: active-low sync
    cur_req = "R2";
    hsync_pol = 0; set_hs(0); wait_cyc(3);
    placement = 2; duration = 3;
    repeat (3) line(1, 9);
    hsync_pol = 1; set_hs(0); wait_cyc(8);

    // R6: external pin, both polarities
    cur_req = "R6";
    clk_src = 1;
    for (int p = 0; p < 2; p++) begin
      ext_pol = p[0];
      for (int k = 0; k < 6; k++) begin
        ext_clamp = k[0];
        wait_cyc(k + 1);
      end
    end
    ext_pol = 1; ext_clamp = 0;

    // R7: source switch mid-pulse, internal counter keeps running
    cur_req = "R7";
    placement = 1; duration = 10;
    set_hs(1); wait_cyc(3);
    clk_src = 1; ext_clamp = 0; wait_cyc(3);
    clk_src = 0; wait_cyc(2);
    set_hs(0); wait_cyc(3);
    clk_src = 1; ext_clamp = 1; wait_cyc(2);
    clk_src = 0; wait_cyc(10);

    // R8: every combination of level selects
    cur_req = "R8";
    for (int s = 0; s < 8; s++) begin
      lvl_sel = s[2:0];
      line(1, 4);
    end

    wait_cyc(2);
    if (hung) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge hung) begin
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule